// File: doc/BRIEF.md
# Three-Wire Synthesizer Word Loader

This block receives configuration words for a frequency synthesizer over a three-wire serial link made of a data line, a shift clock and an active-low frame enable. All three lines are resampled in the block's system clock. While the frame enable is low, every rising edge of the shift clock moves one data bit into a shift register, most significant bit first, and a bit counter advances.

When the frame enable returns high, the number of bits received in that frame picks the destination. A frame of 8 bits updates the control word. A frame of 16 bits fills a staging copy of the reference divider word. A frame of 24 bits updates the loop divider fields and, on the same clock edge, copies the staged reference word to the active reference output. The reference and loop dividers therefore always change together. A frame of any other length is discarded.

The outputs are parallel words that the reference counter, the loop counter and the control logic read directly.

Top module: `synth_word_loader`

## Requirements
- R1: After reset, the reference, control, loop-divider N and loop-divider A outputs all read zero.
- R2: While the frame enable is low, each rising edge of the shift clock takes one data bit, and the first bit of a frame is the most significant bit of the word.
- R3: Shift-clock edges while the frame enable is high leave the shift register and the bit count untouched. The next frame starts counting from zero, and the outputs do not change.
- R4: A 16-bit frame goes only into the reference staging buffer, and the reference output keeps its previous value.
- R5: An 8-bit frame replaces the control output with the 8 received bits once the frame enable rises.
- R6: In a 24-bit frame, received bits 17:6 become the 12-bit N output and bits 5:0 become the 6-bit A output. Bits 23:18 are ignored.
- R7: A 24-bit frame copies the staged reference word to the reference output on the same clock edge that updates N and A. If no new 16-bit frame has arrived in between, the reference output keeps the last staged value.
- R8: A frame of any length other than 8, 16 or 24 bits, including zero bits and more than 24 bits, changes no output and no staged value.
- R9: When several 16-bit frames arrive before a 24-bit frame, only the last of them reaches the reference output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge ends a frame |
| ser_data | input | 1 | Serial data, most significant bit first |
| ref_word | output | REF_W (16) | Active reference divider word |
| ctl_word | output | CTL_W (8) | Control word |
| div_n | output | N_W (12) | Loop divider N field |
| div_a | output | A_W (6) | Loop divider swallow (A) field |

## Verification
The bench uses the default parameters: two synchronizer stages, word lengths of 8, 16 and 24 bits, and a 12-bit N field with a 6-bit A field. The shift clock phases are several system clocks long, so every edge survives the synchronizer. Because the 24-bit frame is longer than the 18 bits that are stored, frames of 25 bits and more exercise the saturating counter and show that the discarded upper bits (23:18) and overlong frames are handled correctly. Frames of 0, 7 and 12 bits show that lengths between the valid sizes are rejected.

// File: rtl/synth_load_pkg.sv
package synth_load_pkg;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_REF  = 2'd1,
      TGT_CTL  = 2'd2,
      TGT_DIV  = 2'd3
   } load_tgt_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ff <= {STAGES{RST_VAL}};
            end else begin
               ff[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  ff[i] <= ff[i-1];
               end
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sl_shifter.sv
module sl_shifter #(
   parameter int SHIFT_W = 18,
   parameter int CNT_W   = 5,
   parameter int CNT_MAX = 25
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck,
   input  logic               sen_n,
   input  logic               sdat,
   output logic [SHIFT_W-1:0] shift_q,
   output logic [CNT_W-1:0]   cnt_q,
   output logic               frame_end
);
   logic sck_d;
   logic sen_d;
   logic sck_rise;

   assign sck_rise  = sck & ~sck_d;
   assign frame_end = sen_n & ~sen_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         sen_d <= 1'b1;
      end else begin
         sck_d <= sck;
         sen_d <= sen_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         cnt_q   <= '0;
      end else if (sen_n) begin
         cnt_q <= '0;
      end else if (sck_rise) begin
         shift_q <= {shift_q[SHIFT_W-2:0], sdat};
         if (cnt_q != CNT_W'(CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R8
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(CNT_MAX));

   // R3
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sen_n) |-> (cnt_q == '0));

   // R3
   shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sck_rise && !sen_n) |=> $stable(shift_q));
endmodule

// File: rtl/sl_commit.sv
module sl_commit
   import synth_load_pkg::*;
#(
   parameter int SHIFT_W = 18,
   parameter int CNT_W   = 5,
   parameter int REF_W   = 16,
   parameter int CTL_W   = 8,
   parameter int DIV_W   = 24,
   parameter int N_W     = 12,
   parameter int A_W     = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_end,
   input  logic [CNT_W-1:0]   cnt,
   input  logic [SHIFT_W-1:0] shift,
   output logic [REF_W-1:0]   ref_q,
   output logic [CTL_W-1:0]   ctl_q,
   output logic [N_W-1:0]     n_q,
   output logic [A_W-1:0]     a_q
);
   localparam int A_LSB = 0;
   localparam int N_LSB = A_W;

   load_tgt_e        tgt;
   logic [REF_W-1:0] ref_stage;

   always_comb begin
      if (cnt == CNT_W'(REF_W))      tgt = TGT_REF;
      else if (cnt == CNT_W'(CTL_W)) tgt = TGT_CTL;
      else if (cnt == CNT_W'(DIV_W)) tgt = TGT_DIV;
      else                           tgt = TGT_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_stage <= '0;
         ref_q     <= '0;
         ctl_q     <= '0;
         n_q       <= '0;
         a_q       <= '0;
      end else if (frame_end) begin
         unique case (tgt)
            TGT_REF: ref_stage <= shift[REF_W-1:0];
            TGT_CTL: ctl_q     <= shift[CTL_W-1:0];
            TGT_DIV: begin
               n_q   <= shift[N_LSB +: N_W];
               a_q   <= shift[A_LSB +: A_W];
               ref_q <= ref_stage;
            end
            default: ;
         endcase
      end
   end

   // R7
   ref_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ref_q) |-> $past(frame_end && tgt == TGT_DIV));

   // R5
   ctl_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctl_q) |-> $past(frame_end && tgt == TGT_CTL));

   // R8
   no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && tgt == TGT_NONE) |=>
         ($stable(ref_q) && $stable(ctl_q) && $stable(n_q) && $stable(a_q)
          && $stable(ref_stage)));
endmodule

// File: rtl/synth_word_loader.sv
module synth_word_loader
   import synth_load_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int REF_W       = 16,
   parameter int CTL_W       = 8,
   parameter int DIV_W       = 24,
   parameter int N_W         = 12,
   parameter int A_W         = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk,
   input  logic             ser_en_n,
   input  logic             ser_data,
   output logic [REF_W-1:0] ref_word,
   output logic [CTL_W-1:0] ctl_word,
   output logic [N_W-1:0]   div_n,
   output logic [A_W-1:0]   div_a
);
   localparam int SHIFT_W = max3(REF_W, CTL_W, N_W + A_W);
   localparam int CNT_MAX = DIV_W + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   generate
      if (REF_W == CTL_W || REF_W == DIV_W || CTL_W == DIV_W) begin : g_bad_len
         $error("frame lengths must be distinct");
      end
      if (N_W + A_W > DIV_W) begin : g_bad_fields
         $error("N and A fields exceed divider frame");
      end
      if (REF_W > DIV_W || CTL_W > DIV_W || SHIFT_W < 2) begin : g_bad_order
         $error("divider frame must be the longest");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must be non-negative");
      end
   endgenerate

   logic sck_s, sen_s, sdat_s;
   logic [SHIFT_W-1:0] shift_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               frame_end;

   sl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sck_s));
   sl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_en (
      .clk(clk), .rst_n(rst_n), .d(ser_en_n), .q(sen_s));
   sl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d(ser_data), .q(sdat_s));

   sl_shifter #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .sck(sck_s), .sen_n(sen_s), .sdat(sdat_s),
      .shift_q(shift_q), .cnt_q(cnt_q), .frame_end(frame_end));

   sl_commit #(
      .SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .REF_W(REF_W), .CTL_W(CTL_W),
      .DIV_W(DIV_W), .N_W(N_W), .A_W(A_W)
   ) u_commit (
      .clk(clk), .rst_n(rst_n),
      .frame_end(frame_end), .cnt(cnt_q), .shift(shift_q),
      .ref_q(ref_word), .ctl_q(ctl_word), .n_q(div_n), .a_q(div_a));

   // R7
   pair_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ref_word) |-> $past(frame_end));
endmodule

// File: tb/synth_word_loader_bench.sv
module synth_word_loader_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PH         = 4;

   typedef struct {
      logic [15:0] r;
      logic [7:0]  c;
      logic [11:0] n;
      logic [5:0]  a;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0;
   logic ser_en_n = 1'b1;
   logic ser_data = 1'b0;
   logic [15:0] ref_word;
   logic [7:0]  ctl_word;
   logic [11:0] div_n;
   logic [5:0]  div_a;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   exp_t q[$];
   event ev_check;
   event ev_monitor_done;

   logic [15:0] m_stage = '0, m_ref = '0;
   logic [7:0]  m_ctl = '0;
   logic [11:0] m_n = '0;
   logic [5:0]  m_a = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   synth_word_loader u_synth_word_loader (
      .clk(clk), .rst_n(rst_n),
      .ser_clk(ser_clk), .ser_en_n(ser_en_n), .ser_data(ser_data),
      .ref_word(ref_word), .ctl_word(ctl_word), .div_n(div_n), .div_a(div_a));

   task automatic cmp(input string tag, input string fld, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, fld, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   // monitor: pops expected items and compares at the falling edge
   initial begin
      forever begin
         @(ev_check);
         @(negedge clk);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "ref", 32'(ref_word), 32'(e.r));
            cmp(e.tag, "ctl", 32'(ctl_word), 32'(e.c));
            cmp(e.tag, "n",   32'(div_n),    32'(e.n));
            cmp(e.tag, "a",   32'(div_a),    32'(e.a));
         end
         ->ev_monitor_done;
      end
   end

   task automatic push_expect(input string tag);
      exp_t e;
      e.r = m_ref; e.c = m_ctl; e.n = m_n; e.a = m_a; e.tag = tag;
      q.push_back(e);
      ->ev_check;
      @(ev_monitor_done);
   endtask

   // driver: one frame of nbits, MSB first, then model update from the requirements
   task automatic send(input int nbits, input logic [31:0] val, input string tag);
      @(negedge clk);
      ser_en_n = 1'b0;
      repeat (PH) @(negedge clk);
      for (int i = nbits - 1; i >= 0; i--) begin
         ser_data = (i < 32) ? val[i] : 1'b1;
         repeat (PH) @(negedge clk);
         ser_clk = 1'b1;
         repeat (PH) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (PH) @(negedge clk);
      ser_en_n = 1'b1;
      repeat (10) @(negedge clk);
      case (nbits)
         16: m_stage = val[15:0];
         8:  m_ctl   = val[7:0];
         24: begin
            m_n   = val[17:6];
            m_a   = val[5:0];
            m_ref = m_stage;
         end
         default: ;
      endcase
      push_expect(tag);
   endtask

   task automatic stray_clocks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ser_data = i[0];
         repeat (PH) @(negedge clk);
         ser_clk = 1'b1;
         repeat (PH) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (10) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      push_expect("R1 reset");

      send(16, 32'h0000_A5C3, "R4 ref staged only");
      send(8,  32'h0000_005A, "R5 control load R2 msb first");
      send(24, 32'h00FC_06D6, "R6 R7 divider fields and ref commit");
      send(7,  32'h0000_007F, "R8 seven bits");
      send(12, 32'h0000_0FFF, "R8 twelve bits");
      send(25, 32'h01FF_FFFF, "R8 overlong frame");
      send(0,  32'h0,         "R8 empty frame");
      send(16, 32'h0000_1234, "R9 first ref");
      send(16, 32'h0000_BEEF, "R9 second ref");
      send(24, 32'h0003_FFFF, "R9 R6 last ref wins, all ones");
      send(24, 32'h00C0_0041, "R7 divider reuses staged ref");
      stray_clocks(5);
      push_expect("R3 clocks while idle ignored");
      send(8,  32'h0000_003C, "R3 count restarts from zero");
      send(8,  32'h0000_0081, "R2 msb and lsb positions");

      finish_run();
   end
endmodule